// File: doc/BRIEF.md
# SD bus clock divisor generator

This block picks a divisor for the SD bus clock and then produces that clock from the base clock. A load strobe latches a parent clock rate, a requested bus rate and a mode bit. The request is first limited to a configured ceiling. A sequential search then tries power-of-two candidates, one per base clock cycle, and stops at the first candidate whose quotient of the parent rate is no larger than the request. The legacy mode never selects a divide-by-one candidate. The newer mode may select it, which makes the bus run at the parent rate.

The chosen candidate becomes a 10-bit divider field, which is the candidate shifted right by one. The block also presents the field in its 16-bit control-word placement and reports the resulting bus rate, which downstream phase-tap logic uses. A one-cycle completion pulse marks the result.

The clock generator uses the field as follows. A field of zero passes the base clock straight through. A non-zero field N gives a period of 2N base cycles, with a 50 % duty cycle. A new field takes effect only where the output is low, so a reconfiguration never shortens a pulse.

Top module: `sdclk_divgen`

## Requirements
- R1: While reset is asserted, `sdClk`, `done`, `divField` and `busRate` are all zero.
- R2: The first candidate is 1 when `newMode` is 1 and 2 when it is 0. Each further candidate doubles the previous one, and the search stops at the first candidate c where parentRate / c ≤ the effective request.
- R3: The field written is the selected candidate divided by two. When the newer mode selects candidate 1, the field is 0.
- R4: When no candidate below 256 qualifies, the candidate is 256, the field is 128 and the bus rate is parentRate / 256.
- R5: `busRate` equals parentRate divided by the selected candidate, with integer truncation.
- R6: A requested rate above MAX_RATE is replaced by MAX_RATE before the search.
- R7: Each cycle examines one candidate. `done` rises k cycles after the loading edge, where k is the number of candidates examined including the selected one. It stays high for one cycle, and `divField` and `busRate` change only in that cycle.
- R8: `divRegBytes[15:8]` carries field bits [7:0] and `divRegBytes[7:6]` carries field bits [9:8]. Bits [5:0] are zero.
- R9: With a field of 0 in effect, `sdClk` follows the base clock: high in its high phase, low in its low phase.
- R10: With a non-zero field N in effect, `sdClk` has a period of 2N base cycles, with N cycles high.
- R11: A change of field takes effect only at a point where `sdClk` is low. Outside reset, no high or low pulse of `sdClk` is shorter than half a base clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadReq | input | 1 | Starts a divisor search with the present inputs |
| newMode | input | 1 | 1: search starts at 1; 0: search starts at 2 |
| parentRate | input | RATE_W | Parent clock rate in Hz |
| reqRate | input | RATE_W | Requested bus rate in Hz |
| divField | output | FIELD_W | Selected divider field |
| divRegBytes | output | 16 | Divider field in its control-word placement |
| busRate | output | RATE_W | Resulting bus rate in Hz |
| done | output | 1 | One-cycle pulse when a search completes |
| sdClk | output | 1 | Generated bus clock |

## Verification
The bench builds the block with MAX_RATE set to 100 MHz. This lets moderate parent rates reach the clamp in both modes, where an uncapped search would choose a different candidate. LIMIT_LOG2 stays at 8 and FIELD_W at 10, so the full ladder is exercised: the nine-cycle worst-case latency, the field value 128 in the upper control-word byte, and the fall-through case with no qualifying candidate. The vector order also moves the generator between divided and pass-through states, so a pulse-width monitor covers every kind of switch.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;

  // Strobes from the search control to the datapath
  typedef struct packed {
    logic start;   // latch inputs, set first candidate
    logic step;    // advance to next candidate
    logic finish;  // commit candidate to field and rate
  } srchStrobe_t;

endpackage

// File: rtl/sdclk_div_ctrl.sv
`timescale 1ns/1ps
module sdclk_div_ctrl
  import sdclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadReq,
  input  logic        hit,
  input  logic        atLimit,
  output srchStrobe_t strobe,
  output logic        done
);

  typedef enum logic {S_IDLE, S_SEARCH} state_t;
  state_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (loadReq) begin
          strobe.start = 1'b1;
          stateNext    = S_SEARCH;
        end
      end
      S_SEARCH: begin
        if (hit || atLimit) begin
          strobe.finish = 1'b1;
          stateNext     = S_IDLE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish;
    end
  end

endmodule

// File: rtl/sdclk_div_path.sv
`timescale 1ns/1ps
module sdclk_div_path
  import sdclk_pkg::*;
#(
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned MAX_RATE   = 200_000_000,
  parameter int unsigned LIMIT_LOG2 = 8,
  parameter int unsigned FIELD_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  srchStrobe_t        strobe,
  input  logic               newMode,
  input  logic [RATE_W-1:0]  parentRate,
  input  logic [RATE_W-1:0]  reqRate,
  output logic               hit,
  output logic               atLimit,
  output logic [FIELD_W-1:0] divField,
  output logic [RATE_W-1:0]  busRate
);

  localparam int unsigned SH_W = $clog2(LIMIT_LOG2 + 1);
  localparam logic [RATE_W-1:0] MAX_Q = RATE_W'(MAX_RATE);
  localparam logic [SH_W-1:0] LIMIT_SH = SH_W'(LIMIT_LOG2);

  logic [RATE_W-1:0]  parentQ, reqQ, reqClamp, quotient;
  logic [SH_W-1:0]    shift, startShift;
  logic [FIELD_W-1:0] fieldOfShift;

  assign reqClamp   = (reqRate > MAX_Q) ? MAX_Q : reqRate;
  assign startShift = newMode ? SH_W'(0) : SH_W'(1);

  // Candidate is 1 << shift; division by it is a right shift
  assign quotient = parentQ >> shift;
  assign hit      = (quotient <= reqQ);
  assign atLimit  = (shift == LIMIT_SH);

  // Field = candidate >> 1
  assign fieldOfShift = (shift == '0) ? '0
                      : (FIELD_W'(1) << SH_W'(shift - SH_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parentQ  <= '0;
      reqQ     <= '0;
      shift    <= '0;
      divField <= '0;
      busRate  <= '0;
    end else begin
      if (strobe.start) begin
        parentQ <= parentRate;
        reqQ    <= reqClamp;
        shift   <= startShift;
      end else if (strobe.step) begin
        shift <= shift + SH_W'(1);
      end
      if (strobe.finish) begin
        divField <= fieldOfShift;
        busRate  <= quotient;
      end
    end
  end

endmodule

// File: rtl/sdclk_div_gen.sv
`timescale 1ns/1ps
module sdclk_div_gen #(
  parameter int unsigned FIELD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] reqField,
  output logic               sdClk
);

  logic [FIELD_W-1:0] activeField, halfCnt;
  logic               divLevel, bypassSel, inBypass, halfEnd, changeReq;

  assign inBypass  = (activeField == '0);
  assign halfEnd   = (halfCnt == activeField - FIELD_W'(1));
  assign changeReq = (reqField != activeField);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeField <= '0;
      halfCnt     <= '0;
      divLevel    <= 1'b0;
    end else if (inBypass) begin
      if (changeReq) begin
        // leave pass-through: start with a full low phase
        activeField <= reqField;
        halfCnt     <= '0;
        divLevel    <= 1'b0;
      end
    end else if (halfEnd) begin
      halfCnt <= '0;
      if (!divLevel && changeReq) begin
        // end of a low phase: switch here, restart low
        activeField <= reqField;
        divLevel    <= 1'b0;
      end else begin
        divLevel <= ~divLevel;
      end
    end else begin
      halfCnt <= halfCnt + FIELD_W'(1);
    end
  end

  // Selector moves while the base clock is low and the divided level is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bypassSel <= 1'b0;
    else        bypassSel <= inBypass;
  end

  assign sdClk = bypassSel ? clk : divLevel;

endmodule

// File: rtl/sdclk_divgen.sv
`timescale 1ns/1ps
module sdclk_divgen
  import sdclk_pkg::*;
#(
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned MAX_RATE   = 200_000_000,
  parameter int unsigned LIMIT_LOG2 = 8,
  parameter int unsigned FIELD_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loadReq,
  input  logic               newMode,
  input  logic [RATE_W-1:0]  parentRate,
  input  logic [RATE_W-1:0]  reqRate,
  output logic [FIELD_W-1:0] divField,
  output logic [15:0]        divRegBytes,
  output logic [RATE_W-1:0]  busRate,
  output logic               done,
  output logic               sdClk
);

  localparam int unsigned HI_W = FIELD_W - 8;

  srchStrobe_t strobe;
  logic        hit, atLimit;

  sdclk_div_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadReq(loadReq), .hit(hit),
    .atLimit(atLimit), .strobe(strobe), .done(done)
  );

  sdclk_div_path #(
    .RATE_W(RATE_W), .MAX_RATE(MAX_RATE),
    .LIMIT_LOG2(LIMIT_LOG2), .FIELD_W(FIELD_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .newMode(newMode),
    .parentRate(parentRate), .reqRate(reqRate), .hit(hit),
    .atLimit(atLimit), .divField(divField), .busRate(busRate)
  );

  sdclk_div_gen #(.FIELD_W(FIELD_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .reqField(divField), .sdClk(sdClk)
  );

  // Low byte of field in [15:8], upper bits in [7:6]
  assign divRegBytes = {divField[7:0], divField[FIELD_W-1:8], (8-HI_W)'(0)};

endmodule

// File: rtl/sdclk_divgen_chk.sv
`timescale 1ns/1ps
module sdclk_divgen_chk #(
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned LIMIT_LOG2 = 8,
  parameter int unsigned FIELD_W    = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic [FIELD_W-1:0] divField,
  input logic [RATE_W-1:0]  busRate
);

  localparam logic [FIELD_W-1:0] FIELD_MAX = FIELD_W'(1) << (LIMIT_LOG2 - 1);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  field_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divField) |-> done);

  // R7
  rate_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(busRate) |-> done);

  // R3 R4
  field_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($onehot0(divField) && (divField <= FIELD_MAX)));

endmodule

bind sdclk_divgen sdclk_divgen_chk #(
  .RATE_W(RATE_W), .LIMIT_LOG2(LIMIT_LOG2), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .divField(divField), .busRate(busRate)
);

// File: tb/sdclk_divgen_bench.sv
`timescale 1ns/1ps
module sdclk_divgen_bench;

  localparam int CLK_P  = 10;
  localparam int RATE_W = 32;
  localparam int FIELD_W = 10;

  typedef struct packed {
    logic              mode;
    logic [31:0]       parent;
    logic [31:0]       req;
    logic [9:0]        field;
    logic [31:0]       bus;
    logic [3:0]        lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd200_000_000, 32'd200_000_000, 10'd1,   32'd100_000_000, 4'd2}, // R6 clamp
    '{1'b1, 32'd50_000_000,  32'd50_000_000,  10'd0,   32'd50_000_000,  4'd1}, // R3
    '{1'b0, 32'd50_000_000,  32'd50_000_000,  10'd1,   32'd25_000_000,  4'd1}, // R2
    '{1'b1, 32'd100_000_000, 32'd25_000_000,  10'd2,   32'd25_000_000,  4'd3},
    '{1'b0, 32'd100_000_000, 32'd30_000_000,  10'd2,   32'd25_000_000,  4'd2},
    '{1'b1, 32'd96_000_000,  32'd750_000,     10'd64,  32'd750_000,     4'd8},
    '{1'b0, 32'd96_000_000,  32'd750_000,     10'd64,  32'd750_000,     4'd7},
    '{1'b1, 32'd100_000_000, 32'd100_000,     10'd128, 32'd390_625,     4'd9}, // R4
    '{1'b0, 32'd100_000_000, 32'd0,           10'd128, 32'd390_625,     4'd8}, // R4
    '{1'b1, 32'd150_000_000, 32'd250_000_000, 10'd1,   32'd75_000_000,  4'd2}, // R6
    '{1'b1, 32'd12_000_000,  32'd6_000_000,   10'd1,   32'd6_000_000,   4'd2},
    '{1'b0, 32'd0,           32'd0,           10'd1,   32'd0,           4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadReq = 1'b0;
  logic newMode = 1'b0;
  logic [RATE_W-1:0] parentRate = '0;
  logic [RATE_W-1:0] reqRate = '0;
  logic [FIELD_W-1:0] divField;
  logic [15:0] divRegBytes;
  logic [RATE_W-1:0] busRate;
  logic done;
  logic sdClk;

  int nChecks = 0;
  int nFails = 0;
  int runts = 0;
  bit finished = 1'b0;
  time lastEdge = 0;

  always #(CLK_P/2) clk = ~clk;

  sdclk_divgen #(
    .RATE_W(RATE_W), .MAX_RATE(100_000_000), .LIMIT_LOG2(8), .FIELD_W(FIELD_W)
  ) u_sdclk_divgen (
    .clk(clk), .rst_n(rst_n), .loadReq(loadReq), .newMode(newMode),
    .parentRate(parentRate), .reqRate(reqRate), .divField(divField),
    .divRegBytes(divRegBytes), .busRate(busRate), .done(done), .sdClk(sdClk)
  );

  // R11: pulse-width monitor
  always @(sdClk) begin
    if (rst_n) begin
      if (($time - lastEdge) < CLK_P/2) runts++;
    end
    lastEdge = $time;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runVector(input vec_t v);
    int lat;
    lat = 0;
    @(negedge clk);
    newMode = v.mode; parentRate = v.parent; reqRate = v.req; loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
    check(lat == int'(v.lat), "R7 latency", lat, v.lat);
    check(divField == v.field, "R2 R3 field", divField, v.field);
    check(busRate == v.bus, "R5 busRate", busRate, v.bus);
    check(divRegBytes == {v.field[7:0], v.field[9:8], 6'b0}, "R8 layout",
          divRegBytes, {v.field[7:0], v.field[9:8], 6'b0});
    @(negedge clk);
    check(!done, "R7 done width", done, 0);
  endtask

  task automatic checkBypass();
    repeat (600) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(sdClk == 1'b1, "R9 high phase", sdClk, 1);
      @(negedge clk); #1;
      check(sdClk == 1'b0, "R9 low phase", sdClk, 0);
    end
  endtask

  task automatic checkPeriod(input int n);
    logic prev, cur;
    int hi, tot;
    bit seen;
    repeat (600) @(negedge clk);
    seen = 1'b0;
    #1 prev = sdClk;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); #1 cur = sdClk;
      if (!prev && cur) begin seen = 1'b1; break; end
      prev = cur;
    end
    hi = 1; tot = 1; prev = 1'b1;
    for (int i = 0; i < 1000 && seen; i++) begin
      @(negedge clk); #1 cur = sdClk;
      if (!prev && cur) break;
      tot++;
      if (cur) hi++;
      prev = cur;
    end
    check(seen && tot == 2*n, "R10 period", tot, 2*n);
    check(seen && hi == n, "R10 high cycles", hi, n);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check(sdClk == 1'b0, "R1 sdClk high phase", sdClk, 0);
      @(negedge clk); #1;
      check(sdClk == 1'b0 && !done, "R1 sdClk/done", sdClk, 0);
    end
    check(divField == '0, "R1 divField", divField, 0);
    check(busRate == '0, "R1 busRate", busRate, 0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VECS[k]) begin
      runVector(VECS[k]);
      if (VECS[k].field == 0) checkBypass();
      else if (VECS[k].field <= 4) checkPeriod(int'(VECS[k].field));
    end

    // R9 again after returning to pass-through from a long divide
    runVector('{1'b1, 32'd40_000_000, 32'd45_000_000, 10'd0, 32'd40_000_000, 4'd1});
    checkBypass();
    runVector('{1'b0, 32'd40_000_000, 32'd5_000_000, 10'd4, 32'd5_000_000, 4'd3});
    checkPeriod(4);

    // R11: no runt pulses across all switches
    check(runts == 0, "R11 runt pulses", runts, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule